// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets a processor reach the management registers of external Ethernet PHYs. Software sees six 32-bit words: a setup word, a command word, a target word, an outgoing-data word, an incoming-data word and a status word. The block turns these accesses into Clause 22 serial frames. It produces the management clock on `mdc` and drives the shared data line through `mdio_o` and `mdio_oe`. The line is read back on `mdio_i`.

A write frame starts as soon as software stores the outgoing-data word. A read frame starts only when bit 0 of the command word changes from 0 to 1, so software clears the bit and then sets it. The status word has two flags. BUSY covers the whole frame on the wire. NOT-VALID stays raised from the start of a read until the captured PHY value has been stored in the incoming-data word. Software polls until both flags are 0 and then reads the result.

Each frame has 64 bits: 32 preamble ones, start `01`, opcode `01` for a write or `10` for a read, a 5-bit PHY address, a 5-bit register number, a 2-bit turnaround and 16 data bits, sent MSB first. One MDC period lasts 4×(div+1) system clocks, where div is the 3-bit divider field. A whole frame therefore lasts 256×(div+1) clocks, which is 20.48 µs at 100 MHz with the reset value of 7.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the status word (index 5) reads 0, the setup word (index 0) reads 0x00000007, `mdc` is low and `mdio_oe` is low.
- R2: The target word (index 2) keeps the PHY address in bits 12:8 and the register number in bits 4:0, and reads back 0 in every other bit. Both fields appear in the next frame.
- R3: Writing the outgoing-data word (index 3) while idle starts a write frame built from bits 15:0. The frame is 32 ones, `01`, `01`, PHY address, register number, `10`, then the 16 data bits, MSB first. `mdio_oe` is high for all 64 bits.
- R4: A read frame starts only on a 0-to-1 change of command bit 0 (index 1). Writing 1 while the bit is already 1 starts nothing.
- R5: A read frame carries opcode `10`. `mdio_oe` is high for bits 0 to 45 and low from bit 46 onward. The 16 bits that the PHY presents in bits 48 to 63 are sampled at the rising edges of `mdc` and are returned in bits 15:0 of the incoming-data word (index 4).
- R6: Status bit 0 (BUSY) is 1 from the clock after a frame starts until the frame ends, and it clears in the cycle the frame ends.
- R7: Status bit 2 (NOT-VALID) is set when a read starts and clears in the same cycle that the read result is stored. A write frame never sets it.
- R8: One MDC half period lasts 2×(div+1) system clocks, where div is setup bits 2:0. A frame keeps BUSY high for exactly 256×(div+1) clocks and gives 64 rising edges of `mdc`.
- R9: An outgoing-data write, or a 0-to-1 command change, that arrives while BUSY is 1 does not start a frame. The stored register value is still updated.
- R10: While setup bit 31 is 1, any frame in progress is abandoned. BUSY, NOT-VALID and the command bit clear, `mdc` stays low, `mdio_oe` stays low, and no access starts a frame.
- R11: While no frame is active, `mdc` is held low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Word index, 0 to 5 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the indexed word (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Data driven on the line |
| mdio_oe | output | 1 | Line drive enable |
| mdio_i | input | 1 | Line value seen by the master |

## Verification
The embedded assertions check these relations on every cycle:
- BUSY and line activity agree in idle.
- NOT-VALID never appears without BUSY.
- A start never arrives while the engine runs.
- The soft reset silences the line within one clock.
- The serial bit position moves only on a falling-edge strobe.

Only the bench scenarios can show the rest:
- that the bit sequence on the line is correct;
- where the line is released during a read;
- the exact frame duration for each divider value;
- the round trip of PHY data into the incoming-data word;
- that repeated or busy-time starts are ignored.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int PHY_W     = 5;
    localparam int RNUM_W    = 5;
    localparam int DAT_W     = 16;
    localparam int FRAME_LEN = 64;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam int TA_POS    = 46;
    localparam int DATA_POS  = 48;

    localparam logic [2:0] W_SETUP  = 3'd0;
    localparam logic [2:0] W_CMD    = 3'd1;
    localparam logic [2:0] W_TARGET = 3'd2;
    localparam logic [2:0] W_TXDATA = 3'd3;
    localparam logic [2:0] W_RXDATA = 3'd4;
    localparam logic [2:0] W_STATUS = 3'd5;

    typedef struct packed {
        logic              is_read;
        logic [PHY_W-1:0]  phy;
        logic [RNUM_W-1:0] rnum;
        logic [DAT_W-1:0]  data;
    } xfer_req_t;

    function automatic logic [FRAME_LEN-1:0] pack_frame(input xfer_req_t r);
        logic [1:0] op;
        op = r.is_read ? 2'b10 : 2'b01;
        return {32'hFFFF_FFFF, 2'b01, op, r.phy, r.rnum, 2'b10,
                (r.is_read ? {DAT_W{1'b1}} : r.data)};
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             level;
    } clk_state_t;

    clk_state_t st_q, st_d;
    logic [CNT_W-1:0] half_m1;
    logic             edge_now;

    always_comb begin
        half_m1  = {div, 1'b1};
        edge_now = run && (st_q.cnt == half_m1);
        rise_stb = edge_now && !st_q.level;
        fall_stb = edge_now && st_q.level;
        st_d     = st_q;
        if (!run) begin
            st_d.cnt   = '0;
            st_d.level = 1'b0;
        end else if (edge_now) begin
            st_d.cnt   = '0;
            st_d.level = !st_q.level;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc = st_q.level && run;

    assert_rise_sets_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> st_q.level);
    assert_fall_clears_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !st_q.level);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               srst,
    input  logic               start,
    input  xfer_req_t          req,
    input  logic               rise_stb,
    input  logic               fall_stb,
    input  logic               mdio_i,
    output logic               active,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               done,
    output logic [DAT_W-1:0]   cap_data
);
    typedef struct packed {
        logic                 active;
        logic                 is_read;
        logic [POS_W-1:0]     pos;
        logic [FRAME_LEN-1:0] shreg;
        logic [DAT_W-1:0]     cap;
    } eng_state_t;

    eng_state_t st_q, st_d;
    logic       last_bit;
    logic       released;

    always_comb begin
        last_bit = (st_q.pos == POS_W'(FRAME_LEN - 1));
        released = st_q.is_read && (st_q.pos >= POS_W'(TA_POS));
        done     = 1'b0;
        st_d     = st_q;
        if (srst) begin
            st_d.active = 1'b0;
            st_d.pos    = '0;
        end else if (!st_q.active) begin
            if (start) begin
                st_d.active  = 1'b1;
                st_d.is_read = req.is_read;
                st_d.pos     = '0;
                st_d.shreg   = pack_frame(req);
            end
        end else begin
            if (rise_stb && st_q.is_read && st_q.pos >= POS_W'(DATA_POS))
                st_d.cap = {st_q.cap[DAT_W-2:0], mdio_i};
            if (fall_stb) begin
                if (last_bit) begin
                    st_d.active = 1'b0;
                    st_d.pos    = '0;
                    done        = 1'b1;
                end else begin
                    st_d.pos   = st_q.pos + 1'b1;
                    st_d.shreg = {st_q.shreg[FRAME_LEN-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.shreg <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign active   = st_q.active;
    assign mdio_o   = st_q.shreg[FRAME_LEN-1];
    assign mdio_oe  = st_q.active && !released;
    assign cap_data = st_q.cap;

    assert_pos_moves_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !fall_stb && !srst) |=> $stable(st_q.pos));
    assert_released_in_read_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.is_read && st_q.pos >= POS_W'(TA_POS)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
    import mdio_mgmt_pkg::*;
#(
    parameter int               DIV_W     = 3,
    parameter logic [DIV_W-1:0] DIV_RESET = '1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [2:0]         reg_idx,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               done,
    input  logic [DAT_W-1:0]   cap_data,
    output logic               start,
    output xfer_req_t          req,
    output logic [DIV_W-1:0]   div,
    output logic               srst,
    output logic               busy
);
    typedef struct packed {
        logic              soft_rst;
        logic [DIV_W-1:0]  div;
        logic              cmd_rd;
        logic [PHY_W-1:0]  phy;
        logic [RNUM_W-1:0] rnum;
        logic [DAT_W-1:0]  txd;
        logic [DAT_W-1:0]  rxd;
        logic              busy;
        logic              nvalid;
        logic              cur_read;
    } bank_state_t;

    bank_state_t st_q, st_d;
    logic        unused_wbits;

    assign unused_wbits = ^{reg_wdata[30:16], reg_wdata[7:5]};

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        req   = '{is_read: 1'b0, phy: st_q.phy, rnum: st_q.rnum, data: st_q.txd};

        if (done) begin
            st_d.busy = 1'b0;
            if (st_q.cur_read) begin
                st_d.rxd    = cap_data;
                st_d.nvalid = 1'b0;
            end
        end

        if (st_q.soft_rst) begin
            st_d.busy   = 1'b0;
            st_d.nvalid = 1'b0;
            st_d.cmd_rd = 1'b0;
        end

        if (reg_wr) begin
            case (reg_idx)
                W_SETUP: begin
                    st_d.soft_rst = reg_wdata[31];
                    st_d.div      = reg_wdata[DIV_W-1:0];
                end
                W_CMD: begin
                    st_d.cmd_rd = reg_wdata[0];
                    if (!st_q.busy && !st_q.soft_rst && reg_wdata[0] && !st_q.cmd_rd) begin
                        start       = 1'b1;
                        req.is_read = 1'b1;
                    end
                end
                W_TARGET: begin
                    st_d.phy  = reg_wdata[12:8];
                    st_d.rnum = reg_wdata[4:0];
                end
                W_TXDATA: begin
                    st_d.txd = reg_wdata[DAT_W-1:0];
                    if (!st_q.busy && !st_q.soft_rst) begin
                        start    = 1'b1;
                        req.data = reg_wdata[DAT_W-1:0];
                    end
                end
                default: ;
            endcase
        end

        if (start) begin
            st_d.busy     = 1'b1;
            st_d.cur_read = req.is_read;
            st_d.nvalid   = req.is_read;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.div <= DIV_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_idx)
            W_SETUP:  reg_rdata = {st_q.soft_rst, {(31-DIV_W){1'b0}}, st_q.div};
            W_CMD:    reg_rdata = {31'b0, st_q.cmd_rd};
            W_TARGET: reg_rdata = {19'b0, st_q.phy, 3'b0, st_q.rnum};
            W_TXDATA: reg_rdata = {16'b0, st_q.txd};
            W_RXDATA: reg_rdata = {16'b0, st_q.rxd};
            W_STATUS: reg_rdata = {29'b0, st_q.nvalid, 1'b0, st_q.busy};
            default:  reg_rdata = '0;
        endcase
    end

    assign div  = st_q.div;
    assign srst = st_q.soft_rst;
    assign busy = st_q.busy;

    assert_start_raises_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> st_q.busy);
    assert_write_keeps_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !req.is_read) |=> !st_q.nvalid);
    assert_nvalid_within_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.nvalid |-> st_q.busy);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int               DIV_W     = 3,
    parameter logic [DIV_W-1:0] DIV_RESET = '1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_idx,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic             start, done, srst, busy, run, rise_stb, fall_stb;
    xfer_req_t        req;
    logic [DIV_W-1:0] div;
    logic [DAT_W-1:0] cap_data;

    mdio_reg_bank #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
        .cap_data(cap_data), .start(start), .req(req), .div(div),
        .srst(srst), .busy(busy)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div), .mdc(mdc),
        .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n), .srst(srst), .start(start), .req(req),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
        .active(run), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done),
        .cap_data(cap_data)
    );

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));
    assert_busy_tracks_engine_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy == run);
    assert_no_start_while_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !start);
    assert_soft_reset_silences_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!busy && !mdio_oe && !mdc));
endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        phy_drive = 1'b1;
    logic [15:0] phy_val = '0;
    logic [63:0] mon_bits = '1;
    int          mon_n = 0;
    int          oe_err = 0;
    logic        mon_read = 1'b0;
    int          nchk = 0;
    int          nfail = 0;
    bit          finished = 1'b0;
    wire         mdio_bus = mdio_oe ? mdio_o : phy_drive;

    always #5 clk = !clk;

    mdio_mgmt_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_bus)
    );

    // PHY model: records every bit seen at the MDC rise, answers reads
    always @(posedge mdc) begin
        int nxt;
        if (mon_n < 64) begin
            mon_bits[63-mon_n] = mdio_bus;
            if (mdio_oe !== !(mon_read && mon_n >= 46)) oe_err++;
        end
        mon_n++;
        nxt = mon_n;
        if (nxt == 47)                 phy_drive = 1'b0;
        else if (nxt >= 48 && nxt < 64) phy_drive = phy_val[63-nxt];
        else                           phy_drive = 1'b1;
    end

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] p,
                                              input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, d};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_idx = idx;
        #1 d = reg_rdata;
    endtask

    // counts status samples with BUSY set; called right after the starting write
    task automatic wait_idle(output int cyc, output int nv_drop, input bit is_read);
        cyc = 0; nv_drop = 0;
        reg_idx = 3'd5;
        #1;
        while (reg_rdata[0] && cyc < 5000) begin
            cyc++;
            if (is_read && !reg_rdata[2]) nv_drop++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic run_txn(input bit is_rd, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d, input logic [2:0] dv);
        int cyc, nvd;
        logic [31:0] v;
        wr(3'd0, {29'b0, dv});
        wr(3'd2, {19'b0, p, 3'b0, r});
        mon_n = 0; oe_err = 0; mon_read = is_rd; phy_val = d; phy_drive = 1'b1;
        if (is_rd) begin
            wr(3'd1, 32'd0);
            wr(3'd1, 32'd1);
        end else begin
            wr(3'd3, {16'b0, d});
        end
        wait_idle(cyc, nvd, is_rd);
        chk(is_rd ? "R5 frame bits" : "R3 frame bits", mon_bits, exp_frame(is_rd, p, r, d));
        chk(is_rd ? "R5 drive enable" : "R3 drive enable", 64'(oe_err), 64'd0);
        chk("R8 busy duration", 64'(cyc), 64'(256 * (int'(dv) + 1)));
        chk("R8 mdc rises", 64'(mon_n), 64'd64);
        chk("R7 not-valid held during frame", 64'(nvd), 64'd0);
        chk("R6 R7 status after frame", 64'(reg_rdata), 64'd0);
        if (is_rd) begin
            rd(3'd4, v);
            chk("R5 read data", 64'(v), 64'({16'b0, d}));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int cyc, nvd, seed;
        seed = $urandom(32'h1F2E);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R11: reset state
        rd(3'd5, v); chk("R1 status reset", 64'(v), 64'd0);
        rd(3'd0, v); chk("R1 setup reset", 64'(v), 64'h7);
        chk("R1 R11 idle line", 64'({mdc, mdio_oe}), 64'd0);

        // R2: target field placement
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R2 target fields", 64'(v), 64'h1F1F);

        // R3 write at reset divider, R5 read
        run_txn(1'b0, 5'h11, 5'h04, 16'hA5C3, 3'd7);
        run_txn(1'b1, 5'h1F, 5'h00, 16'h8001, 3'd0);

        // R4: writing 1 again while command bit is already 1
        mon_n = 0;
        wr(3'd1, 32'd1);
        repeat (20) @(negedge clk);
        rd(3'd5, v); chk("R4 no restart status", 64'(v), 64'd0);
        chk("R4 no mdc activity", 64'(mon_n), 64'd0);

        // R9: starts requested while busy are ignored, value still stored
        wr(3'd0, 32'd1);
        wr(3'd2, {19'b0, 5'h03, 3'b0, 5'h1A});
        mon_n = 0; oe_err = 0; mon_read = 1'b0;
        wr(3'd3, 32'h0000_1357);
        wr(3'd3, 32'h0000_BEEF);
        wr(3'd1, 32'd0);
        wr(3'd1, 32'd1);
        wait_idle(cyc, nvd, 1'b0);
        repeat (40) @(negedge clk);
        rd(3'd5, v); chk("R9 idle after single frame", 64'(v), 64'd0);
        chk("R9 one frame only", 64'(mon_n), 64'd64);
        chk("R9 first data sent", mon_bits, exp_frame(1'b0, 5'h03, 5'h1A, 16'h1357));
        rd(3'd3, v); chk("R9 data word stored", 64'(v), 64'hBEEF);

        // R10: soft reset aborts a read
        wr(3'd0, 32'd3);
        mon_n = 0; mon_read = 1'b1;
        wr(3'd1, 32'd0);
        wr(3'd1, 32'd1);
        repeat (300) @(negedge clk);
        wr(3'd0, 32'h8000_0000);
        @(negedge clk);
        #1 chk("R10 line quiet", 64'({mdc, mdio_oe}), 64'd0);
        rd(3'd5, v); chk("R10 flags cleared", 64'(v), 64'd0);
        rd(3'd1, v); chk("R10 command cleared", 64'(v), 64'd0);
        mon_n = 0;
        wr(3'd3, 32'h0000_7777);
        repeat (30) @(negedge clk);
        rd(3'd5, v); chk("R10 no start in reset", 64'(v), 64'd0);
        chk("R10 mdc held low", 64'(mon_n), 64'd0);
        wr(3'd0, 32'd7);
        rd(3'd0, v); chk("R10 setup restored", 64'(v), 64'h7);

        // random mix of frames
        for (int i = 0; i < 12; i++) begin
            logic [4:0]  p, r;
            logic [15:0] d;
            logic [2:0]  dv;
            p  = 5'($urandom);
            r  = 5'($urandom);
            d  = 16'($urandom);
            dv = 3'($urandom % 4);
            run_txn(1'($urandom), p, r, d, dv);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule